// File: doc/BRIEF.md
# Masked Hit Combiner with Per-Channel Rate Counters

The block takes sixteen binary hit lines from front-end discriminators and turns them into a smaller set of logical channels for a trigger. Each input first passes through a two-flop synchronizer. A per-channel mask bit then removes a noisy or dead input. The surviving inputs are OR-ed in adjacent groups of two, four or eight, as the grouping mode selects, and the results drive up to eight registered logical outputs.

Every physical channel also has a 24-bit hit counter, so that noise and hit rates can be monitored channel by channel. A counter counts rising edges of its synchronized, unmasked input and saturates at all-ones. A simple register port gives the host read and write access to the mask, the grouping mode and every counter. A command write clears all counters at once. A counter read is captured into the read-data register at the read edge, so the host always sees one consistent 24-bit value.

Top module: `hit_or_combiner`

## Requirements
- R1: After reset, log_o is 0, the mask and all counters are 0, the mode is pairwise (code 0), and reg_rdata_o is 0.
- R2: A change on hit_i reaches log_o on the third rising clock edge after it is applied, and not before.
- R3: In mode code 0, log_o[k] is the OR of unmasked inputs 2k and 2k+1, for k = 0..7.
- R4: In mode code 1, log_o[k] is the OR of unmasked inputs 4k..4k+3 for k = 0..3, and log_o[7:4] is 0. In mode codes 2 and 3, log_o[k] is the OR of unmasked inputs 8k..8k+7 for k = 0..1, and log_o[7:2] is 0.
- R5: Bit i of the mask register (address 0) set to 1 removes input i from log_o and from counter i.
- R6: A counter rises by exactly one for each rising edge of its unmasked input, however long the input stays high.
- R7: A counter that holds 24'hFFFFFF stays there on further hits.
- R8: A write to address 2 with data bit 0 set zeroes all sixteen counters at that clock edge. The clear wins over a hit edge and over a counter write at the same edge.
- R9: A read strobe loads reg_rdata_o at that edge with the addressed value, zero-extended. Addresses 16+i return counter i in bits [23:0]. reg_rdata_o then holds that value until the next read, even while the counter keeps changing.
- R10: The mask (address 0, bits [15:0]) and the mode (address 1, bits [1:0]) read back as written. A write to address 16+i loads counter i with data bits [23:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hit_i | input | 16 | Asynchronous physical-channel hit lines |
| log_o | output | 8 | Registered logical-channel outputs |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 5 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data |

## Verification
On every cycle the assertions check the following:
- unused logical outputs stay low in the four- and eight-input grouping modes;
- the clear command empties every counter;
- a masked or saturated counter does not move;
- a counter never advances by more than one per cycle;
- the read-data register holds between read strobes.

Only the bench scenarios can show the rest:
- the exact OR mapping of every input in each grouping mode;
- the three-edge input latency;
- one count per pulse rather than per high cycle;
- the clear winning over a hit edge at the same clock edge;
- the snapshot value staying fixed while the live counter moves on.

// File: rtl/hit_or_pkg.sv
package hit_or_pkg;
  typedef enum logic [1:0] {
    GRP_2  = 2'd0,
    GRP_4  = 2'd1,
    GRP_8  = 2'd2,
    GRP_8B = 2'd3
  } grp_mode_e;

  localparam int unsigned ADDR_MASK = 0;
  localparam int unsigned ADDR_MODE = 1;
  localparam int unsigned ADDR_CMD  = 2;
endpackage

// File: rtl/hit_sync.sv
module hit_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level_o = sync_q;
  assign rise_o  = sync_q & ~prev_q;
endmodule

// File: rtl/or_combiner.sv
module or_combiner
  import hit_or_pkg::*;
#(
  parameter int unsigned NUM_IN  = 16,
  parameter int unsigned NUM_OUT = 8
) (
  input  logic [NUM_IN-1:0]  in_i,
  input  grp_mode_e          mode_i,
  output logic [NUM_OUT-1:0] out_o
);
  localparam int unsigned N2 = NUM_IN / 2;
  localparam int unsigned N4 = NUM_IN / 4;
  localparam int unsigned N8 = NUM_IN / 8;

  logic [NUM_OUT-1:0] or2, or4, or8;

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    if (k < N2) begin : g_2
      assign or2[k] = |in_i[2*k +: 2];
    end else begin : g_2z
      assign or2[k] = 1'b0;
    end
    if (k < N4) begin : g_4
      assign or4[k] = |in_i[4*k +: 4];
    end else begin : g_4z
      assign or4[k] = 1'b0;
    end
    if (k < N8) begin : g_8
      assign or8[k] = |in_i[8*k +: 8];
    end else begin : g_8z
      assign or8[k] = 1'b0;
    end
  end

  always_comb begin
    case (mode_i)
      GRP_2:   out_o = or2;
      GRP_4:   out_o = or4;
      default: out_o = or8;
    endcase
  end
endmodule

// File: rtl/rate_counter.sv
module rate_counter #(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (wr_i) begin
      cnt_q <= wdata_i;
    end else if (inc_i && cnt_q != MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/hit_or_combiner.sv
module hit_or_combiner
  import hit_or_pkg::*;
#(
  parameter int unsigned NUM_CH  = 16,
  parameter int unsigned NUM_LOG = 8,
  parameter int unsigned CNT_W   = 24,
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CH-1:0]  hit_i,
  output logic [NUM_LOG-1:0] log_o,
  input  logic               reg_we_i,
  input  logic               reg_re_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o
);
  localparam int unsigned IDX_W = ADDR_W - 1;

  logic [NUM_CH-1:0]             mask_q;
  grp_mode_e                     mode_q;
  logic [NUM_CH-1:0][CNT_W-1:0]  cnt_q;
  logic [NUM_CH-1:0]             cnt_wr;
  logic [NUM_CH-1:0]             sync_lvl, sync_rise;
  logic [NUM_LOG-1:0]            comb_log, log_q;
  logic [DATA_W-1:0]             rd_next, rdata_q;
  logic                          clr_cmd, is_cnt;
  logic [IDX_W-1:0]              cnt_idx;

  // Upper half of the address space selects the counters.
  assign is_cnt  = reg_addr_i[ADDR_W-1];
  assign cnt_idx = reg_addr_i[IDX_W-1:0];
  assign clr_cmd = reg_we_i && !is_cnt &&
                   reg_addr_i == ADDR_W'(ADDR_CMD) && reg_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      mode_q <= GRP_2;
    end else if (reg_we_i && !is_cnt) begin
      if (reg_addr_i == ADDR_W'(ADDR_MASK)) mask_q <= reg_wdata_i[NUM_CH-1:0];
      if (reg_addr_i == ADDR_W'(ADDR_MODE)) mode_q <= grp_mode_e'(reg_wdata_i[1:0]);
    end
  end

  hit_sync #(.W(NUM_CH)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (hit_i),
    .level_o (sync_lvl),
    .rise_o  (sync_rise)
  );

  or_combiner #(.NUM_IN(NUM_CH), .NUM_OUT(NUM_LOG)) u_comb (
    .in_i   (sync_lvl & ~mask_q),
    .mode_i (mode_q),
    .out_o  (comb_log)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) log_q <= '0;
    else         log_q <= comb_log;
  end
  assign log_o = log_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_cnt
    assign cnt_wr[i] = reg_we_i && is_cnt && cnt_idx == IDX_W'(i);
    rate_counter #(.W(CNT_W)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clr_cmd),
      .wr_i    (cnt_wr[i]),
      .wdata_i (reg_wdata_i[CNT_W-1:0]),
      .inc_i   (sync_rise[i] & ~mask_q[i]),
      .cnt_o   (cnt_q[i])
    );
  end

  always_comb begin
    rd_next = '0;
    if (is_cnt) begin
      if (int'(cnt_idx) < NUM_CH) rd_next[CNT_W-1:0] = cnt_q[cnt_idx];
    end else if (reg_addr_i == ADDR_W'(ADDR_MASK)) begin
      rd_next[NUM_CH-1:0] = mask_q;
    end else if (reg_addr_i == ADDR_W'(ADDR_MODE)) begin
      rd_next[1:0] = mode_q;
    end
  end

  // Snapshot: value captured at the read edge, held until the next read.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (reg_re_i) rdata_q <= rd_next;
  end
  assign reg_rdata_o = rdata_q;
endmodule

// File: rtl/hit_or_combiner_chk.sv
module hit_or_combiner_chk #(
  parameter int unsigned NUM_CH  = 16,
  parameter int unsigned NUM_LOG = 8,
  parameter int unsigned CNT_W   = 24,
  parameter int unsigned DATA_W  = 32
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [NUM_LOG-1:0]           log_o,
  input logic [1:0]                   mode_q,
  input logic [NUM_CH-1:0]            mask_q,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt_q,
  input logic [NUM_CH-1:0]            cnt_wr,
  input logic                         clr_cmd,
  input logic                         reg_re_i,
  input logic [DATA_W-1:0]            reg_rdata_o
);
  localparam logic [CNT_W-1:0] MAX = '1;

  // R4: outputs above the active group count stay low
  p_or4_unused_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 2'd1) |=> (log_o[NUM_LOG-1:NUM_CH/4] == '0));
  p_or8_unused_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q[1]) |=> (log_o[NUM_LOG-1:NUM_CH/8] == '0));

  p_clear_all_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_cmd |=> (cnt_q == '0));

  p_rdata_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_re_i |=> $stable(reg_rdata_o));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    p_masked_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mask_q[i] && !clr_cmd && !cnt_wr[i]) |=> $stable(cnt_q[i]));
    p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q[i] == MAX && !clr_cmd && !cnt_wr[i]) |=> (cnt_q[i] == MAX));
    p_single_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_cmd && !cnt_wr[i]) |=>
        (cnt_q[i] == $past(cnt_q[i]) || cnt_q[i] == CNT_W'($past(cnt_q[i]) + 1'b1)));
  end
endmodule

bind hit_or_combiner hit_or_combiner_chk #(
  .NUM_CH(NUM_CH), .NUM_LOG(NUM_LOG), .CNT_W(CNT_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .log_o       (log_o),
  .mode_q      (mode_q),
  .mask_q      (mask_q),
  .cnt_q       (cnt_q),
  .cnt_wr      (cnt_wr),
  .clr_cmd     (clr_cmd),
  .reg_re_i    (reg_re_i),
  .reg_rdata_o (reg_rdata_o)
);

// File: tb/hit_or_combiner_test.sv
module hit_or_combiner_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] hit = '0;
  logic [7:0]  log_w;
  logic        we = 1'b0, re = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hit_or_combiner uut (
    .clk_i(clk), .rst_ni(rst_n), .hit_i(hit), .log_o(log_w),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    d = rdata;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int ch, input int n);
    repeat (n) begin
      hit[ch] = 1'b1; cycles(3);
      hit[ch] = 1'b0; cycles(3);
    end
  endtask

  function automatic logic [7:0] exp_log(logic [15:0] h, logic [15:0] m, logic [1:0] md);
    logic [7:0] res;
    logic [15:0] a;
    int gs;
    res = '0;
    a = h & ~m;
    gs = (md == 2'd0) ? 2 : (md == 2'd1) ? 4 : 8;
    for (int k = 0; k < 8; k++)
      if (k < 16 / gs)
        for (int b = 0; b < gs; b++)
          if (a[k*gs+b]) res[k] = 1'b1;
    return res;
  endfunction

  function automatic logic [15:0] pat(int idx);
    if (idx < 16) return 16'h0001 << idx;
    case (idx)
      16: return 16'hFFFF;
      17: return 16'h8001;
      18: return 16'h0180;
      default: return 16'h3C0F;
    endcase
  endfunction

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    cycles(3);
    rst_n = 1'b1;
    cycles(1);

    // R1 reset state
    chk("R1 log_o", 32'(log_w), 32'h0);
    chk("R1 rdata", rdata, 32'h0);
    rd(5'd0, d);  chk("R1 mask", d, 32'h0);
    rd(5'd1, d);  chk("R1 mode", d, 32'h0);
    rd(5'd20, d); chk("R1 counter", d, 32'h0);

    // R10 readback
    wr(5'd0, 32'hFFFF_A5A5); rd(5'd0, d); chk("R10 mask readback", d, 32'h0000_A5A5);
    wr(5'd1, 32'h0000_0006); rd(5'd1, d); chk("R10 mode readback", d, 32'h2);
    wr(5'd0, 32'h0); wr(5'd1, 32'h0);

    // R2 latency: not visible after two edges, visible after three
    hit = 16'h0001;
    cycles(2); chk("R2 before third edge", 32'(log_w), 32'h0);
    cycles(1); chk("R2 at third edge", 32'(log_w), 32'h1);
    hit = '0; cycles(3);

    // R3/R4 grouping sweep over all modes
    for (int md = 0; md < 4; md++) begin
      wr(5'd1, 32'(md));
      for (int p = 0; p < 20; p++) begin
        hit = pat(p);
        cycles(3);
        chk(md == 0 ? "R3 OR2 map" : "R4 OR4/OR8 map", 32'(log_w),
            32'(exp_log(pat(p), 16'h0, 2'(md))));
      end
      hit = '0; cycles(3);
    end

    // R5 masking on outputs
    wr(5'd0, 32'h0000_00F0);
    for (int md = 0; md < 3; md++) begin
      wr(5'd1, 32'(md));
      for (int p = 0; p < 20; p++) begin
        hit = pat(p);
        cycles(3);
        chk("R5 masked output", 32'(log_w), 32'(exp_log(pat(p), 16'h00F0, 2'(md))));
      end
      hit = '0; cycles(3);
    end

    // Counters: clear, then one count per pulse, masked channel frozen
    wr(5'd0, 32'h0000_0020);
    wr(5'd1, 32'h0);
    wr(5'd2, 32'h1);
    pulse(3, 5);
    pulse(5, 3);
    hit[9] = 1'b1; cycles(20); hit[9] = 1'b0; cycles(4);
    rd(5'd19, d); chk("R6 five pulses", d, 32'd5);
    rd(5'd21, d); chk("R5 masked counter", d, 32'd0);
    rd(5'd25, d); chk("R6 long high counts once", d, 32'd1);

    // R9 snapshot holds while counter moves
    rd(5'd19, d);
    pulse(3, 2);
    chk("R9 snapshot held", rdata, 32'd5);
    rd(5'd19, d); chk("R9 fresh read", d, 32'd7);

    // R7 saturation, R10 counter write
    wr(5'd23, 32'hAAFF_FFFE);
    rd(5'd23, d); chk("R10 counter write", d, 32'h00FF_FFFE);
    pulse(7, 3);
    rd(5'd23, d); chk("R7 saturate", d, 32'h00FF_FFFF);

    // R8 clear beats a hit edge at the same clock edge
    hit[3] = 1'b1;
    cycles(2);
    wr(5'd2, 32'h1);
    cycles(2);
    rd(5'd19, d); chk("R8 clear wins over edge", d, 32'd0);
    hit[3] = 1'b0; cycles(3);
    pulse(4, 2);
    wr(5'd2, 32'h1);
    for (int i = 0; i < 16; i++) begin
      rd(5'(16 + i), d);
      chk("R8 all cleared", d, 32'd0);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule